// File: doc/BRIEF.md
# Multi-Cycle 32-bit Load/Store Core

This block is a small non-pipelined 32-bit processor that executes one instruction at a time. Each instruction moves through a chain of one-cycle phases (fetch, decode with register read, execute, memory access, register write-back) and takes only the phases it needs. A single adder serves every phase. Between phases the values are held in internal registers: the instruction word, two operand latches, the adder result and the loaded data word.

The core contains its own instruction and data memories. While reset is held, the surrounding logic or a testbench writes program words and data words into them through a one-word-per-cycle load port. After reset is released, execution starts at address 0 and continues until a halt instruction is decoded. The ports show the program counter, a halt flag and every register-file write as it happens.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted, pc_o is 0, halted is 0 and wb_en is 0. After reset, every general register reads as 0.
- R2: Fetch loads the word addressed by PC[7:2] and advances PC by 4. The cycle counts are: add, addi, sw, beq and bne take 4 cycles, lw takes 5, j and jr take 3, and halt and undefined words each take 2 cycles before the next fetch or the halted state.
- R3: add has opcode 1 in [31:26] and function code 1 in [10:0]. It writes reg[[25:21]] + reg[[20:16]] into reg[[15:11]].
- R4: addi has opcode 2. It writes reg[[25:21]] + sign-extended [15:0] into reg[[20:16]].
- R5: lw has opcode 3. It writes the data word at word index (reg[[25:21]] + sign-extended imm)[7:2] into reg[[20:16]].
- R6: sw has opcode 4. It stores reg[[20:16]] at the address formed as in R5 and makes no register write.
- R7: beq (opcode 5) branches when reg[[25:21]] equals reg[[20:16]], and bne (opcode 6) branches when they differ. A taken branch sets PC to PC+4 + 4*sign-extended imm in its memory phase. A branch that is not taken leaves PC at PC+4.
- R8: j (opcode 7) sets PC to {(PC+4)[31:28], [25:0], 2'b00}. jr (opcode 8) sets PC to reg[[25:21]].
- R9: A write to register 0 is dropped and never shows on wb_en. Register 0 always reads 0.
- R10: halt (opcode 63) raises halted, which then stays high. pc_o holds the halt address + 4, and no register write occurs afterwards.
- R11: Any other opcode, and opcode 1 with a function code other than 1, executes as a no-op.
- R12: wb_en is high for exactly one cycle for each instruction that writes a nonzero register, in that instruction's last cycle, with wb_idx and wb_data giving the register and the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; the load port is meant for use while it is low |
| ld_en | input | 1 | Write ld_data into a memory this cycle |
| ld_dmem | input | 1 | 1 selects the data memory, 0 the instruction memory |
| ld_addr | input | LAW (6) | Word index for the load port |
| ld_data | input | 32 | Word to write |
| pc_o | output | 32 | Current program counter |
| halted | output | 1 | The core has decoded a halt instruction |
| wb_en | output | 1 | Register write this cycle |
| wb_idx | output | 5 | Destination register of the write |
| wb_data | output | 32 | Value written |

## Verification
The hardest behaviour to reach from the ports is the memory phase of a branch whose outcome depends on operands computed a few instructions earlier. The bench also has to show that the branch's effect appears only through which later writes happen. The stimulus sweeps one program over eight operand sets, alternating equal and unequal register pairs so that beq and bne are each taken and not taken. A jr is placed after an undefined word, and a loop closed by a backward bne runs for a different trip count on every sweep. A bench-side instruction-level model gives the expected write sequence, final PC and total cycle count.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [5:0]  OP_ADD_R = 6'd1;
  localparam logic [5:0]  OP_ADDI  = 6'd2;
  localparam logic [5:0]  OP_LW    = 6'd3;
  localparam logic [5:0]  OP_SW    = 6'd4;
  localparam logic [5:0]  OP_BEQ   = 6'd5;
  localparam logic [5:0]  OP_BNE   = 6'd6;
  localparam logic [5:0]  OP_J     = 6'd7;
  localparam logic [5:0]  OP_JR    = 6'd8;
  localparam logic [5:0]  OP_HALT  = 6'd63;
  localparam logic [10:0] FN_ADD   = 11'd1;

  typedef enum logic [2:0] {PH_F, PH_D, PH_X, PH_M, PH_W, PH_H} phase_e;
  typedef enum logic [3:0] {K_RR, K_ADDI, K_LW, K_SW, K_BEQ, K_BNE,
                            K_J, K_JR, K_HALT, K_NOP} kind_e;

  function automatic kind_e f_kind(input logic [XLEN-1:0] w);
    case (w[31:26])
      OP_ADD_R: return (w[10:0] == FN_ADD) ? K_RR : K_NOP;
      OP_ADDI:  return K_ADDI;
      OP_LW:    return K_LW;
      OP_SW:    return K_SW;
      OP_BEQ:   return K_BEQ;
      OP_BNE:   return K_BNE;
      OP_J:     return K_J;
      OP_JR:    return K_JR;
      OP_HALT:  return K_HALT;
      default:  return K_NOP;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] f_sext(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_add(input logic [XLEN-1:0] a,
                                            input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic [XLEN-1:0] f_jtarget(input logic [XLEN-1:0] pc,
                                                input logic [25:0] t);
    return {pc[31:28], t, 2'b00};
  endfunction

  function automatic phase_e f_next(input phase_e ph, input kind_e k);
    case (ph)
      PH_F: return PH_D;
      PH_D: begin
        if (k == K_HALT) return PH_H;
        if (k == K_NOP)  return PH_F;
        return PH_X;
      end
      PH_X: begin
        if (k == K_RR || k == K_ADDI) return PH_W;
        if (k == K_J  || k == K_JR)   return PH_F;
        return PH_M;
      end
      PH_M: return (k == K_LW) ? PH_W : PH_F;
      PH_W: return PH_F;
      PH_H: return PH_H;
      default: return PH_F;
    endcase
  endfunction
endpackage

// File: rtl/mc_mem.sv
`timescale 1ns/1ps
module mc_mem #(
  parameter int AW = 6,
  parameter int DW = 32,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile
  import mc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RAW-1:0]  ra1,
  input  logic [RAW-1:0]  ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [RAW-1:0]  wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_fsm.sv
`timescale 1ns/1ps
module mc_fsm
  import mc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  kind_e  kind,
  output phase_e phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_F;
    else        phase <= f_next(phase, kind);
  end
endmodule

// File: rtl/mc_core.sv
`timescale 1ns/1ps
module mc_core
  import mc_pkg::*;
#(
  parameter int IAW = 6,
  parameter int DAW = 6,
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic            ld_dmem,
  input  logic [LAW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  output logic [XLEN-1:0] pc_o,
  output logic            halted,
  output logic            wb_en,
  output logic [RAW-1:0]  wb_idx,
  output logic [XLEN-1:0] wb_data
);
  phase_e          phase;
  kind_e           kind;
  logic [XLEN-1:0] pc, ir, a_q, b_q, alu_q, mdr_q;
  logic            br_taken;
  logic            is_branch;
  logic [XLEN-1:0] imm_sx, alu_a, alu_b, alu_y;
  logic [XLEN-1:0] rd1, rd2, imem_q, dmem_q;
  logic [RAW-1:0]  wb_dest;
  logic            store_fire, ld_dm_sel;
  logic            dm_we;
  logic [DAW-1:0]  dm_waddr;
  logic [XLEN-1:0] dm_wdata;

  assign kind      = f_kind(ir);
  assign imm_sx    = f_sext(ir[15:0]);
  assign is_branch = (kind == K_BEQ) || (kind == K_BNE);
  assign wb_dest   = (kind == K_RR) ? ir[15:11] : ir[20:16];

  mc_fsm u_fsm (.clk(clk), .rst_n(rst_n), .kind(kind), .phase(phase));

  // one adder serves next-PC, ALU ops, addresses and branch targets
  always_comb begin
    alu_a = a_q;
    alu_b = imm_sx;
    if (phase == PH_F) begin
      alu_a = pc;
      alu_b = 32'd4;
    end else if (is_branch) begin
      alu_a = pc;
      alu_b = {imm_sx[XLEN-3:0], 2'b00};
    end else if (kind == K_RR) begin
      alu_b = b_q;
    end
  end
  assign alu_y = f_add(alu_a, alu_b);

  mc_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(ir[25:21]), .ra2(ir[20:16]), .rd1(rd1), .rd2(rd2),
    .we(wb_en), .wa(wb_dest), .wd(wb_data)
  );

  mc_mem #(.AW(IAW), .DW(XLEN)) u_imem (
    .clk(clk), .we(ld_en && !ld_dmem), .waddr(ld_addr[IAW-1:0]),
    .wdata(ld_data), .raddr(pc[IAW+1:2]), .rdata(imem_q)
  );

  assign store_fire = (phase == PH_M) && (kind == K_SW);
  assign ld_dm_sel  = ld_en && ld_dmem;
  assign dm_we      = ld_dm_sel || store_fire;
  assign dm_waddr   = ld_dm_sel ? ld_addr[DAW-1:0] : alu_q[DAW+1:2];
  assign dm_wdata   = ld_dm_sel ? ld_data : b_q;

  mc_mem #(.AW(DAW), .DW(XLEN)) u_dmem (
    .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr(alu_q[DAW+1:2]), .rdata(dmem_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      ir       <= '0;
      a_q      <= '0;
      b_q      <= '0;
      alu_q    <= '0;
      mdr_q    <= '0;
      br_taken <= 1'b0;
    end else begin
      case (phase)
        PH_F: begin
          ir <= imem_q;
          pc <= alu_y;
        end
        PH_D: begin
          a_q <= rd1;
          b_q <= rd2;
        end
        PH_X: begin
          alu_q    <= alu_y;
          br_taken <= ((kind == K_BEQ) && (a_q == b_q)) ||
                      ((kind == K_BNE) && (a_q != b_q));
          if (kind == K_J)  pc <= f_jtarget(pc, ir[25:0]);
          if (kind == K_JR) pc <= a_q;
        end
        PH_M: begin
          if (kind == K_LW) mdr_q <= dmem_q;
          if (is_branch && br_taken) pc <= alu_q;
        end
        default: ;
      endcase
    end
  end

  assign pc_o    = pc;
  assign halted  = (phase == PH_H);
  assign wb_en   = (phase == PH_W) && (wb_dest != '0);
  assign wb_idx  = wb_dest;
  assign wb_data = (kind == K_LW) ? mdr_q : alu_q;
endmodule

// File: rtl/mc_core_chk.sv
`timescale 1ns/1ps
module mc_core_chk
  import mc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input phase_e          phase,
  input kind_e           kind,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] ir,
  input logic            br_taken,
  input logic            is_branch,
  input logic            halted,
  input logic            wb_en,
  input logic [RAW-1:0]  wb_idx
);
  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_F |=> pc == $past(pc) + 32'd4);

  p_wb_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> phase == PH_W);

  p_wb_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en && phase == PH_F);

  p_no_zero_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_idx != '0);

  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc) && !wb_en);

  p_branch_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_M && is_branch && !br_taken) |=> pc == $past(pc));

  p_jump_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_X && kind == K_J) |=>
      pc == {$past(pc[31:28]), $past(ir[25:0]), 2'b00});
endmodule

bind mc_core mc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .kind(kind), .pc(pc), .ir(ir),
  .br_taken(br_taken), .is_branch(is_branch), .halted(halted),
  .wb_en(wb_en), .wb_idx(wb_idx)
);

// File: tb/sim_mc_core.sv
`timescale 1ns/1ps
module sim_mc_core;
  import mc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0, ld_dmem = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, wb_data;
  logic        halted, wb_en;
  logic [4:0]  wb_idx;

  always #2.5 clk = ~clk;

  mc_core u0 (.clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
              .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
              .halted(halted), .wb_en(wb_en), .wb_idx(wb_idx),
              .wb_data(wb_data));

  int n_cmp = 0, n_bad = 0;
  logic [31:0] prog [64];
  logic [31:0] dm_ref [64];
  logic [31:0] rf_ref [32];
  logic [4:0]  ex_idx [256];
  logic [31:0] ex_dat [256];
  string       ex_req [256];
  int          n_exp, exp_cycles;
  logic [31:0] exp_pc;
  logic [4:0]  ac_idx [256];
  logic [31:0] ac_dat [256];
  int          n_act = 0;

  always @(negedge clk) begin
    if (rst_n && wb_en && n_act < 256) begin
      ac_idx[n_act] = wb_idx;
      ac_dat[n_act] = wb_data;
      n_act++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e_rr(int rd, int rs1, int rs2, int fn);
    return {OP_ADD_R, rs1[4:0], rs2[4:0], rd[4:0], fn[10:0]};
  endfunction
  function automatic logic [31:0] e_i(logic [5:0] op, int rt, int rs1, int imm);
    return {op, rs1[4:0], rt[4:0], imm[15:0]};
  endfunction

  string ctl_tag;
  task automatic put(input int idx, input logic [31:0] v, input string req);
    if (idx != 0) begin
      rf_ref[idx] = v;
      ex_idx[n_exp] = idx[4:0];
      ex_dat[n_exp] = v;
      ex_req[n_exp] = {req, ctl_tag};
      n_exp++;
    end
  endtask

  // instruction-level model built from the requirements
  task automatic ref_run();
    logic [31:0] p, np, w, simm, ea;
    int rs, rt, rd;
    bit done;
    p = 0; exp_cycles = 0; n_exp = 0; done = 0; ctl_tag = "";
    for (int i = 0; i < 32; i++) rf_ref[i] = 0;
    for (int step = 0; step < 2000 && !done; step++) begin
      w = prog[(p / 4) % 64];
      rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
      simm = {{16{w[15]}}, w[15:0]};
      ea = rf_ref[rs] + simm;
      np = p + 4;
      case (w[31:26])
        OP_ADD_R: if (w[10:0] == 11'd1) begin
                    put(rd, rf_ref[rs] + rf_ref[rt], "R3 R9"); exp_cycles += 4;
                  end else exp_cycles += 2;
        OP_ADDI: begin put(rt, ea, "R4"); exp_cycles += 4; end
        OP_LW:   begin put(rt, dm_ref[(ea / 4) % 64], "R5 R6"); exp_cycles += 5; end
        OP_SW:   begin dm_ref[(ea / 4) % 64] = rf_ref[rt]; exp_cycles += 4; end
        OP_BEQ, OP_BNE: begin
          if ((rf_ref[rs] == rf_ref[rt]) == (w[31:26] == OP_BEQ)) np = np + simm * 4;
          exp_cycles += 4; ctl_tag = " R7";
        end
        OP_J:  begin np = {np[31:28], w[25:0], 2'b00}; exp_cycles += 3; ctl_tag = " R8"; end
        OP_JR: begin np = rf_ref[rs]; exp_cycles += 3; ctl_tag = " R8"; end
        OP_HALT: begin exp_cycles += 2; done = 1; end
        default: exp_cycles += 2;
      endcase
      p = np;
    end
    exp_pc = p;
  endtask

  task automatic build(input int t);
    int a, b;
    a = t * 1000 - 3000;
    b = (t % 2 == 0) ? a : a + 7 * t + 1;
    for (int i = 0; i < 64; i++) begin prog[i] = 32'h0; dm_ref[i] = 32'h0; end
    dm_ref[3] = 32'h1234_0000 + t;
    prog[0]  = e_i(OP_ADDI, 1, 0, a);
    prog[1]  = e_i(OP_ADDI, 2, 0, b);
    prog[2]  = e_rr(3, 1, 2, 1);
    prog[3]  = e_i(OP_SW, 3, 0, 8);
    prog[4]  = e_i(OP_LW, 4, 0, 8);
    prog[5]  = e_i(OP_LW, 5, 0, 12);
    prog[6]  = e_i(OP_BEQ, 2, 1, 2);
    prog[7]  = e_i(OP_ADDI, 6, 0, 111);
    prog[8]  = e_i(OP_BNE, 2, 1, 1);
    prog[9]  = e_i(OP_ADDI, 7, 0, 222);
    prog[10] = e_i(OP_ADDI, 0, 0, 5);
    prog[11] = e_rr(8, 0, 3, 1);
    prog[12] = {OP_J, 26'd14};
    prog[13] = e_i(OP_ADDI, 9, 0, 333);
    prog[14] = e_i(OP_ADDI, 10, 0, 80);
    prog[15] = e_i(OP_ADDI, 13, 0, t + 1);
    prog[16] = {6'd42, 26'h155};
    prog[17] = e_rr(15, 1, 2, 5);
    prog[18] = {OP_JR, 5'd10, 21'd0};
    prog[19] = e_i(OP_ADDI, 11, 0, 444);
    prog[20] = e_i(OP_ADDI, 12, 12, 1);
    prog[21] = e_i(OP_BNE, 13, 12, -2);
    prog[22] = e_i(OP_SW, 12, 0, 16);
    prog[23] = e_i(OP_LW, 14, 0, 16);
    prog[24] = {OP_HALT, 26'd0};
  endtask

  task automatic run_case(input int t);
    int cyc;
    logic [31:0] pc_hold;
    int n_hold;
    build(t);
    rst_n = 1'b0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_dmem = (i >= 64); ld_addr = 6'(i % 64);
      ld_data = (i >= 64) ? dm_ref[i - 64] : prog[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    chk("R1 pc in reset", pc_o, 32'h0);
    chk("R1 halted in reset", {31'b0, halted}, 32'h0);
    chk("R1 wb_en in reset", {31'b0, wb_en}, 32'h0);
    ref_run();
    n_act = 0;
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    chk("R2 R11 cycles to halt", cyc, exp_cycles);
    chk("R10 pc at halt", pc_o, exp_pc);
    chk("R9 R12 write count", n_act, n_exp);
    for (int k = 0; k < n_exp && k < n_act; k++) begin
      chk({ex_req[k], " wb_idx"}, {27'b0, ac_idx[k]}, {27'b0, ex_idx[k]});
      chk({ex_req[k], " wb_data"}, ac_dat[k], ex_dat[k]);
    end
    pc_hold = pc_o; n_hold = n_act;
    repeat (4) @(negedge clk);
    chk("R10 halted sticks", {31'b0, halted}, 32'h1);
    chk("R10 pc held", pc_o, pc_hold);
    chk("R10 no writes after halt", n_act, n_hold);
    rst_n = 1'b0;
  endtask

  initial begin
    for (int t = 0; t < 8; t++) run_case(t);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule